// File: doc/BRIEF.md
# Oversampled Clock Phase Monitor

The block observes a slow clock that may be gated, and a much faster related clock measures it. Two flops in the slow domain act on opposite edges: one toggles on the rising edge and one follows it on the falling edge. The XOR of the two flops follows the slow clock's level. Because this copy is ordinary data, the slow clock net never has to drive a logic input.

In the fast domain the copy passes through a synchronizer. A phase counter then measures how many fast samples each high and each low phase lasts. A phase that ends shorter than a programmable minimum is a glitch. A phase that runs past a programmable maximum is a stall. A stall usually means that the clock has been gated off or has stopped. A saturating counter keeps the number of glitches, and a record holds the most recent fault. A synchronous clear input empties both.

With a 12:1 clock ratio, a nominal phase lasts 6 samples. A typical setting is a minimum of 4 and a maximum of about 9. A pulse narrower than one fast period may go unseen.

Top module: `clk_phase_mon`

## Requirements
- R1: `rebuilt_o` is 0 after reset. It goes to 1 on every rising edge of `slow_clk_i` and to 0 on every falling edge, so it always carries the slow clock's level.
- R2: While `rst_ni` is low, every output is 0.
- R3: A phase is measured as the number of fast-clock samples at one level. When a phase ends with fewer than `min_len_i` samples, `glitch_o` is 1 for one cycle. That cycle starts on the third rising edge of `fast_clk_i` after the slow edge that ended the phase.
- R4: The phase that is in progress when reset is released produces no glitch and no stall, however long it lasts.
- R5: When a phase reaches its (`max_len_i`+1)-th sample, `stall_o` rises. For a phase starting on a slow edge just after fast edge k, that is at fast edge k+`max_len_i`+3. It stays 1 until the next transition and falls on the third fast edge after that transition.
- R6: `glitch_cnt_o` counts glitches, one per cycle in which `glitch_o` is 1. It saturates at 2^GLITCH_W-1 and never wraps.
- R7: Each fault overwrites the fault record. After a glitch the record holds `fault_vld_o`=1, `fault_stall_o`=0, `fault_pol_o` = the level of the short phase (1 = high phase) and `fault_len_o` = its sample count. After a stall it holds `fault_vld_o`=1, `fault_stall_o`=1, `fault_pol_o` = the stalled level and `fault_len_o` = `max_len_i`.
- R8: `clr_i` sets the glitch counter and the whole fault record to 0 on the next fast edge. A fault that is reported in the same cycle is applied after the clear, so the counter reads 1 and the record holds that fault.
- R9: A phase whose length lies between `min_len_i` and `max_len_i`, both limits included, changes neither the counter, the record nor `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk_i | input | 1 | Monitored clock, possibly gated |
| fast_clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| clr_i | input | 1 | Synchronous clear of counter and record (fast domain) |
| min_len_i | input | CNT_W | Shortest legal phase in samples |
| max_len_i | input | CNT_W | Longest legal phase in samples |
| rebuilt_o | output | 1 | Slow clock level rebuilt as data (slow domain) |
| glitch_o | output | 1 | One-cycle pulse per short phase |
| stall_o | output | 1 | Current phase has exceeded the maximum |
| glitch_cnt_o | output | GLITCH_W | Saturating glitch count |
| fault_vld_o | output | 1 | Fault record holds a fault |
| fault_stall_o | output | 1 | Recorded fault was a stall |
| fault_pol_o | output | 1 | Level of the faulty phase |
| fault_len_o | output | CNT_W | Sample count of the faulty phase |

## Verification
A glitch report and a clear can fall in the same fast cycle, because the clear comes from outside and the glitch comes from the slow clock. The bench first saturates the counter with runt phases. It then ends a 2-sample phase, waits at the falling fast edge for `glitch_o` to go high, and raises `clr_i` for exactly that cycle. The outcome is judged at the ports: the counter must read 1, not 0 and not the saturated value, and the record must hold the 2-sample fault. The checker also holds that a clear with no fault in the same cycle leaves everything at 0.

// File: rtl/clk_mon_pkg.sv
package clk_mon_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GLITCH = 2'd1,
    FLT_STALL  = 2'd2
  } flt_kind_e;

  localparam int unsigned CNT_W_DEF       = 6;
  localparam int unsigned GLITCH_W_DEF    = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/clk_rebuild.sv
// Dual-edge toggle pair: XOR of the two flops follows the slow clock level.
module clk_rebuild (
  input  logic slow_clk_i,
  input  logic rst_ni,
  output logic rebuilt_o
);
  logic rise_q, fall_q;

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= 1'b0;
    else         rise_q <= ~fall_q;
  end

  always_ff @(negedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= rise_q;
  end

  assign rebuilt_o = rise_q ^ fall_q;
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/phase_meter.sv
module phase_meter
  import clk_mon_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic [CNT_W-1:0] min_len_i,
  input  logic [CNT_W-1:0] max_len_i,
  output flt_kind_e        evt_kind_o,
  output logic [CNT_W-1:0] evt_len_o,
  output logic             evt_pol_o,
  output logic             stall_o
);
  localparam logic [CNT_W-1:0] CntSat = '1;

  logic             lvl_q, armed_q, stall_q, pol_q;
  logic [CNT_W-1:0] cnt_q, len_q;
  flt_kind_e        kind_q;
  logic             trans, runt, over;

  assign trans = level_i ^ lvl_q;
  // at a transition cnt_q holds the full length of the phase just ended
  assign runt  = armed_q & trans & (cnt_q < min_len_i);
  assign over  = armed_q & ~trans & ~stall_q & (cnt_q == max_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
      stall_q <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= FLT_NONE;
      len_q   <= '0;
      pol_q   <= 1'b0;
    end else begin
      lvl_q <= level_i;
      if (trans) armed_q <= 1'b1;

      if (trans)                cnt_q <= CNT_W'(1);
      else if (cnt_q != CntSat) cnt_q <= cnt_q + 1'b1;

      if (trans)     stall_q <= 1'b0;
      else if (over) stall_q <= 1'b1;

      kind_q <= runt ? FLT_GLITCH : (over ? FLT_STALL : FLT_NONE);
      len_q  <= cnt_q;
      pol_q  <= lvl_q;
    end
  end

  assign evt_kind_o = kind_q;
  assign evt_len_o  = len_q;
  assign evt_pol_o  = pol_q;
  assign stall_o    = stall_q;
endmodule

// File: rtl/fault_log.sv
module fault_log
  import clk_mon_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned GLITCH_W = GLITCH_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  flt_kind_e           evt_kind_i,
  input  logic [CNT_W-1:0]    evt_len_i,
  input  logic                evt_pol_i,
  output logic [GLITCH_W-1:0] glitch_cnt_o,
  output logic                vld_o,
  output logic                stall_o,
  output logic                pol_o,
  output logic [CNT_W-1:0]    len_o
);
  localparam logic [GLITCH_W-1:0] GlitchSat = '1;

  logic [GLITCH_W-1:0] cnt_q, cnt_d;
  logic                vld_q, stall_q, pol_q;
  logic [CNT_W-1:0]    len_q;

  // clear first, then apply a same-cycle event
  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q;
    if (evt_kind_i == FLT_GLITCH && cnt_d != GlitchSat) cnt_d = cnt_d + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      stall_q <= 1'b0;
      pol_q   <= 1'b0;
      len_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (evt_kind_i != FLT_NONE) begin
        vld_q   <= 1'b1;
        stall_q <= (evt_kind_i == FLT_STALL);
        pol_q   <= evt_pol_i;
        len_q   <= evt_len_i;
      end else if (clr_i) begin
        vld_q   <= 1'b0;
        stall_q <= 1'b0;
        pol_q   <= 1'b0;
        len_q   <= '0;
      end
    end
  end

  assign glitch_cnt_o = cnt_q;
  assign vld_o        = vld_q;
  assign stall_o      = stall_q;
  assign pol_o        = pol_q;
  assign len_o        = len_q;
endmodule

// File: rtl/clk_phase_mon.sv
module clk_phase_mon
  import clk_mon_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned GLITCH_W    = GLITCH_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                slow_clk_i,
  input  logic                fast_clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [CNT_W-1:0]    min_len_i,
  input  logic [CNT_W-1:0]    max_len_i,
  output logic                rebuilt_o,
  output logic                glitch_o,
  output logic                stall_o,
  output logic [GLITCH_W-1:0] glitch_cnt_o,
  output logic                fault_vld_o,
  output logic                fault_stall_o,
  output logic                fault_pol_o,
  output logic [CNT_W-1:0]    fault_len_o
);
  logic             rebuilt, level_s, evt_pol;
  logic [CNT_W-1:0] evt_len;
  flt_kind_e        evt_kind;

  clk_rebuild u_rebuild (
    .slow_clk_i (slow_clk_i),
    .rst_ni     (rst_ni),
    .rebuilt_o  (rebuilt)
  );

  bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (fast_clk_i),
    .rst_ni (rst_ni),
    .d_i    (rebuilt),
    .q_o    (level_s)
  );

  phase_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i      (fast_clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level_s),
    .min_len_i  (min_len_i),
    .max_len_i  (max_len_i),
    .evt_kind_o (evt_kind),
    .evt_len_o  (evt_len),
    .evt_pol_o  (evt_pol),
    .stall_o    (stall_o)
  );

  fault_log #(.CNT_W(CNT_W), .GLITCH_W(GLITCH_W)) u_log (
    .clk_i        (fast_clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_i),
    .evt_kind_i   (evt_kind),
    .evt_len_i    (evt_len),
    .evt_pol_i    (evt_pol),
    .glitch_cnt_o (glitch_cnt_o),
    .vld_o        (fault_vld_o),
    .stall_o      (fault_stall_o),
    .pol_o        (fault_pol_o),
    .len_o        (fault_len_o)
  );

  assign rebuilt_o = rebuilt;
  assign glitch_o  = (evt_kind == FLT_GLITCH);
endmodule

// File: rtl/clk_phase_mon_chk.sv
module clk_phase_mon_chk #(
  parameter int unsigned GLITCH_W = 8
) (
  input logic                fast_clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                glitch_o,
  input logic                stall_o,
  input logic [GLITCH_W-1:0] glitch_cnt_o,
  input logic                fault_vld_o,
  input logic                fault_stall_o
);
  localparam logic [GLITCH_W-1:0] CntSat = '1;

  p_glitch_logged_r7: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    glitch_o |=> (fault_vld_o && !fault_stall_o));

  p_stall_logged_r7: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    $rose(stall_o) |=> (fault_vld_o && fault_stall_o));

  p_cnt_after_glitch_r6: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    glitch_o |=> (glitch_cnt_o != '0));

  p_sat_hold_r6: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    (glitch_cnt_o == CntSat && !clr_i) |=> (glitch_cnt_o == CntSat));

  p_cnt_step_r6: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    !clr_i |=> (glitch_cnt_o == $past(glitch_cnt_o) ||
                glitch_cnt_o == GLITCH_W'($past(glitch_cnt_o) + 1'b1)));

  p_clear_r8: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    (clr_i && !glitch_o && !$rose(stall_o)) |=> (glitch_cnt_o == '0 && !fault_vld_o));

  p_no_overlap_r5: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    glitch_o |-> !stall_o);
endmodule

bind clk_phase_mon clk_phase_mon_chk #(.GLITCH_W(GLITCH_W)) u_chk (
  .fast_clk_i    (fast_clk_i),
  .rst_ni        (rst_ni),
  .clr_i         (clr_i),
  .glitch_o      (glitch_o),
  .stall_o       (stall_o),
  .glitch_cnt_o  (glitch_cnt_o),
  .fault_vld_o   (fault_vld_o),
  .fault_stall_o (fault_stall_o)
);

// File: tb/clk_phase_mon_tb.sv
module clk_phase_mon_tb;
  localparam int CW   = 6;
  localparam int GW   = 4;
  localparam int MINL = 4;
  localparam int MAXL = 9;
  localparam int NOM  = 6;
  localparam int GSAT = (1 << GW) - 1;

  logic          fast_clk = 1'b0;
  logic          slow_clk = 1'b0;
  logic          rst_n    = 1'b0;
  logic          clr      = 1'b0;
  logic [CW-1:0] min_len  = CW'(MINL);
  logic [CW-1:0] max_len  = CW'(MAXL);
  logic          rebuilt, glitch, stall, f_vld, f_stall, f_pol;
  logic [GW-1:0] g_cnt;
  logic [CW-1:0] f_len;

  clk_phase_mon #(.CNT_W(CW), .GLITCH_W(GW)) u_dut (
    .slow_clk_i    (slow_clk),
    .fast_clk_i    (fast_clk),
    .rst_ni        (rst_n),
    .clr_i         (clr),
    .min_len_i     (min_len),
    .max_len_i     (max_len),
    .rebuilt_o     (rebuilt),
    .glitch_o      (glitch),
    .stall_o       (stall),
    .glitch_cnt_o  (g_cnt),
    .fault_vld_o   (f_vld),
    .fault_stall_o (f_stall),
    .fault_pol_o   (f_pol),
    .fault_len_o   (f_len)
  );

  always #4 fast_clk = ~fast_clk;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  bit cur_lvl = 1'b0;
  int cur_len = 1000;
  bit m_armed = 1'b0;
  int m_cnt   = 0;
  bit m_vld = 1'b0, m_stall = 1'b0, m_pol = 1'b0;
  int m_len = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_vld = 0; m_stall = 0; m_pol = 0; m_len = 0;
  endtask

  // ends the current phase and opens a new one of the opposite level
  task automatic model_phase(input int len, output bit lvl);
    lvl = !cur_lvl;
    if (m_armed && cur_len < MINL) begin
      m_cnt   = (m_cnt == GSAT) ? m_cnt : m_cnt + 1;
      m_vld   = 1; m_stall = 0; m_pol = cur_lvl; m_len = cur_len;
    end
    m_armed = 1;
    cur_lvl = lvl;
    cur_len = len;
    if (len > MAXL) begin
      m_vld = 1; m_stall = 1; m_pol = lvl; m_len = MAXL;
    end
  endtask

  // every phase starts 2 ns after a fast rising edge and spans len samples
  task automatic phase(input int len);
    bit l;
    model_phase(len, l);
    slow_clk = l;
    repeat (len) @(posedge fast_clk);
    #2;
  endtask

  task automatic checkpoint(input string tag, input bit do_clr);
    bit l;
    model_phase(NOM, l);
    slow_clk = l;
    repeat (5) @(posedge fast_clk);
    @(negedge fast_clk);
    chk({tag, " R1 rebuilt level"}, rebuilt, l);
    chk({tag, " R6 glitch count"}, g_cnt, m_cnt);
    chk({tag, " R7 record valid"}, f_vld, m_vld);
    chk({tag, " R7 record stall"}, f_stall, m_stall);
    chk({tag, " R7 record polarity"}, f_pol, m_pol);
    chk({tag, " R7 record length"}, f_len, m_len);
    chk({tag, " R5 stall released"}, stall, 0);
    if (do_clr) begin
      clr = 1'b1;
      model_clear();
    end
    @(posedge fast_clk);
    #2;
    clr = 1'b0;
  endtask

  initial begin
    bit l;
    void'($urandom(32'd20140711));

    // reset state
    repeat (3) @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R2 rebuilt", rebuilt, 0);
    chk("R2 glitch", glitch, 0);
    chk("R2 stall", stall, 0);
    chk("R2 count", g_cnt, 0);
    chk("R2 record", {f_vld, f_stall, f_pol, f_len}, 0);
    @(posedge fast_clk);
    #2;
    rst_n = 1'b1;

    // first phase: long low after reset, must stay silent
    repeat (30) @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R4 no stall in first phase", stall, 0);
    chk("R1 rebuilt low after reset", rebuilt, 0);
    @(posedge fast_clk);
    #2;
    phase(NOM);
    checkpoint("R4", 1'b0);

    // limits inclusive
    phase(MINL); phase(MAXL); phase(5); phase(8); phase(MINL); phase(MAXL);
    checkpoint("R9", 1'b0);
    chk("R9 nothing counted", g_cnt, 0);

    // stall timing: rise, hold, release
    model_phase(20, l);
    slow_clk = l;
    repeat (MAXL + 2) @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R5 stall not yet", stall, 0);
    @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R5 stall raised", stall, 1);
    repeat (20 - MAXL - 3) @(posedge fast_clk);
    #2;
    model_phase(NOM, l);
    slow_clk = l;
    repeat (2) @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R5 stall held to transition", stall, 1);
    @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R5 stall cleared", stall, 0);
    repeat (3) @(posedge fast_clk);
    #2;
    checkpoint("R5", 1'b0);

    // random phase lengths with periodic clears
    for (int i = 0; i < 100; i++) begin
      phase(int'($urandom_range(13, 1)));
      if (i % 4 == 3) checkpoint("R3 random", $urandom_range(2, 0) == 0);
    end
    checkpoint("R8 cleared", 1'b1);
    checkpoint("R8 after clear", 1'b0);

    // saturation
    for (int i = 0; i < 20; i++) phase(2);
    checkpoint("R6 saturate", 1'b0);
    chk("R6 saturated value", g_cnt, GSAT);

    // clear in the same cycle as a glitch report
    phase(2);
    model_clear();
    model_phase(NOM, l);
    slow_clk = l;
    repeat (2) @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R3 glitch not early", glitch, 0);
    @(posedge fast_clk);
    @(negedge fast_clk);
    chk("R3 glitch on third edge", glitch, 1);
    clr = 1'b1;
    @(posedge fast_clk);
    #2;
    clr = 1'b0;
    @(negedge fast_clk);
    chk("R3 glitch single cycle", glitch, 0);
    @(posedge fast_clk);
    #2;
    checkpoint("R8 race", 1'b0);
    chk("R8 race count", g_cnt, 1);
    chk("R8 race length", f_len, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge fast_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule